// File: doc/BRIEF.md
# PCI Window DMA Address Translator

This block turns an address seen on the PCI bus into a system DMA address. Four programmable windows describe which regions of the bus address space are remapped. Each window has a base register, a size mask register and a translated-base register. All of them are supplied as inputs by the surrounding control register block. A request carries one bus address. The block picks the first enabled window that covers the address and returns a 34-bit DMA address as a single-cycle response pulse.

A window maps in one of two ways. In direct mode it replaces the upper bits of the bus address with bits from the translated base. In scatter-gather mode the translated base points at a page table in memory. The block builds a page-table-entry address from the table base and the page index taken from the bus address. It fetches the 64-bit entry through a read port, then joins the page frame from the entry with the page offset from the bus address. An address that no enabled window covers is passed back unchanged. Only one translation is in flight at a time.

Top module: `pwt_xlate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rsp_valid_o` and `rd_req_valid_o` are 0 and `req_ready_o` is 1.
- R2: Window i covers a bus address when the address equals base register i on every bit in 31:20 whose bit in mask register i is 0. Mask bits outside 31:20 take no part in the compare.
- R3: Windows are tried in the order 0, 1, 2, 3. The first window that covers the address and has base bit 0 (enable) set is used. A covering window whose enable is clear is skipped.
- R4: Base bit 1 set selects scatter-gather mode and clear selects direct mode. In direct mode, let keep = (mask bits 31:20) OR 0xFFFFF. The result is (translated base AND NOT keep) OR (bus address AND keep), 34 bits wide.
- R5: When no enabled window covers the address, the response is the bus address zero-extended to 34 bits.
- R6: For direct and pass-through requests, `rsp_valid_o` is 1 for exactly one cycle: the cycle after the request is accepted (`req_valid_i` and `req_ready_o` both 1 at a clock edge).
- R7: In scatter-gather mode, `rd_req_valid_o` rises the cycle after acceptance and stays high with a steady address until `rd_req_ready_i` is seen. The address is (translated base AND NOT ((mask bits 31:20) >> 10 OR 0x3FF)) OR ((bus AND ((mask bits 31:20) OR 0xFE000)) >> 10). While a scatter-gather translation is pending, `req_ready_o` is 0 and new requests are not accepted.
- R8: In scatter-gather mode, `rsp_valid_o` rises the cycle after `rd_rsp_valid_i` is seen while the block awaits the entry. The result is bits 33:0 of ((entry AND NOT 1) << 12) OR (bus AND 0x1FFF).
- R9: `rd_rsp_valid_i` has no effect unless the block awaits an entry, and no response is produced on the cycle after a scatter-gather request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | 32 | Bus address to translate |
| win_base_i | input | 128 | Window base registers, window i in bits 32i+31:32i; bit 0 enable, bit 1 scatter-gather |
| win_mask_i | input | 128 | Window size masks, same packing; bits 31:20 used |
| win_xlat_i | input | 136 | Translated base registers, window i in bits 34i+33:34i |
| rd_req_valid_o | output | 1 | Page-table-entry read request valid |
| rd_req_ready_i | input | 1 | Memory accepts the read request |
| rd_req_addr_o | output | 34 | Page-table-entry address |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_data_i | input | 64 | Page-table entry |
| rsp_valid_o | output | 1 | Translation result valid, one-cycle pulse |
| rsp_addr_o | output | 34 | Translated DMA address |

## Verification
The bench builds the block with its default parameters: four windows, a 32-bit bus address, a 34-bit DMA address and 64-bit entries. The window inputs are changed between phases. This lets one bus address fall into overlapping windows, hit a disabled window before an enabled one, and miss every window. The translated bases set bit 33 and the page-table entries carry high bits past the 34-bit limit, so both the direct path and the truncation of the scatter-gather result are tested. The memory side holds the read request for several cycles and sends a stray read response and a stray request while the fetch is pending.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } fsm_e;

endpackage

// File: rtl/pwt_match.sv
module pwt_match #(
    parameter int NUM_WIN = 4,
    parameter int BUS_AW  = 32,
    parameter int SEL_LO  = 20,
    parameter int SEL_HI  = 31,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [BUS_AW-1:0]         bus_addr,
    input  logic [NUM_WIN*BUS_AW-1:0] base_flat,
    input  logic [NUM_WIN*BUS_AW-1:0] mask_flat,
    output logic                      hit,
    output logic                      sg,
    output logic [IDX_W-1:0]          sel
);

    logic [NUM_WIN-1:0] cand;
    logic [NUM_WIN-1:0] sg_bit;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic [BUS_AW-1:0] base_w;
        logic [BUS_AW-1:0] cmp_w;
        assign base_w = base_flat[w*BUS_AW +: BUS_AW];
        for (genvar b = 0; b < BUS_AW; b++) begin : g_bit
            if (b >= SEL_LO && b <= SEL_HI) begin : g_in
                assign cmp_w[b] = ~mask_flat[w*BUS_AW + b];
            end else begin : g_out
                assign cmp_w[b] = 1'b0;
            end
        end
        assign cand[w]   = (((bus_addr ^ base_w) & cmp_w) == '0) && base_w[0];
        assign sg_bit[w] = base_w[1];
    end

    always_comb begin
        sel = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (cand[i]) begin
                sel = IDX_W'(i);
            end
        end
    end

    assign hit = |cand;
    assign sg  = hit && sg_bit[sel];

endmodule

// File: rtl/pwt_map.sv
module pwt_map #(
    parameter int BUS_AW   = 32,
    parameter int DMA_AW   = 34,
    parameter int SEL_LO   = 20,
    parameter int SEL_HI   = 31,
    parameter int IDX_LO   = 13,
    parameter int ENTRY_SH = 10
) (
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_AW-1:0] win_mask,
    input  logic [DMA_AW-1:0] win_xlat,
    output logic [DMA_AW-1:0] direct_addr,
    output logic [DMA_AW-1:0] entry_addr
);

    localparam logic [DMA_AW-1:0] LOW_KEEP  = (DMA_AW'(1) << SEL_LO) - DMA_AW'(1);
    localparam logic [DMA_AW-1:0] TBL_LOW   = (DMA_AW'(1) << ENTRY_SH) - DMA_AW'(1);
    localparam logic [DMA_AW-1:0] BELOW_IDX = (DMA_AW'(1) << IDX_LO) - DMA_AW'(1);

    logic [DMA_AW-1:0] bus_x;
    logic [DMA_AW-1:0] mask_x;
    logic [DMA_AW-1:0] field;
    logic [DMA_AW-1:0] keep;
    logic [DMA_AW-1:0] tbl_clr;
    logic [DMA_AW-1:0] idx_mask;

    always_comb begin
        bus_x  = DMA_AW'(bus_addr);
        mask_x = DMA_AW'(win_mask);
        for (int b = 0; b < DMA_AW; b++) begin
            field[b] = (b >= SEL_LO && b <= SEL_HI) ? mask_x[b] : 1'b0;
        end
        keep        = field | LOW_KEEP;
        tbl_clr     = (field >> ENTRY_SH) | TBL_LOW;
        idx_mask    = field | (LOW_KEEP & ~BELOW_IDX);
        direct_addr = (win_xlat & ~keep) | (bus_x & keep);
        entry_addr  = (win_xlat & ~tbl_clr) | ((bus_x & idx_mask) >> ENTRY_SH);
    end

endmodule

// File: rtl/pwt_xlate.sv
module pwt_xlate #(
    parameter int NUM_WIN  = 4,
    parameter int BUS_AW   = 32,
    parameter int DMA_AW   = 34,
    parameter int PTE_W    = 64,
    parameter int SEL_LO   = 20,
    parameter int SEL_HI   = 31,
    parameter int IDX_LO   = 13,
    parameter int ENTRY_SH = 10,
    parameter int PAGE_SH  = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid_i,
    output logic                      req_ready_o,
    input  logic [BUS_AW-1:0]         req_addr_i,
    input  logic [NUM_WIN*BUS_AW-1:0] win_base_i,
    input  logic [NUM_WIN*BUS_AW-1:0] win_mask_i,
    input  logic [NUM_WIN*DMA_AW-1:0] win_xlat_i,
    output logic                      rd_req_valid_o,
    input  logic                      rd_req_ready_i,
    output logic [DMA_AW-1:0]         rd_req_addr_o,
    input  logic                      rd_rsp_valid_i,
    input  logic [PTE_W-1:0]          rd_rsp_data_i,
    output logic                      rsp_valid_o,
    output logic [DMA_AW-1:0]         rsp_addr_o
);
    import pwt_pkg::*;

    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int OFF_W = IDX_LO;

    typedef struct packed {
        fsm_e              fsm;
        logic              rsp_vld;
        logic [DMA_AW-1:0] rsp_addr;
        logic [DMA_AW-1:0] rd_addr;
        logic [OFF_W-1:0]  off;
    } st_t;

    st_t st_d, st_q;

    logic              hit;
    logic              hit_sg;
    logic [IDX_W-1:0]  sel;
    logic [BUS_AW-1:0] sel_mask;
    logic [DMA_AW-1:0] sel_xlat;
    logic [DMA_AW-1:0] direct_addr;
    logic [DMA_AW-1:0] entry_addr;
    logic [PTE_W-1:0]  pte_clr;
    logic [DMA_AW-1:0] sg_addr;

    pwt_match #(
        .NUM_WIN (NUM_WIN),
        .BUS_AW  (BUS_AW),
        .SEL_LO  (SEL_LO),
        .SEL_HI  (SEL_HI)
    ) u_match (
        .bus_addr  (req_addr_i),
        .base_flat (win_base_i),
        .mask_flat (win_mask_i),
        .hit       (hit),
        .sg        (hit_sg),
        .sel       (sel)
    );

    assign sel_mask = win_mask_i[sel*BUS_AW +: BUS_AW];
    assign sel_xlat = win_xlat_i[sel*DMA_AW +: DMA_AW];

    pwt_map #(
        .BUS_AW   (BUS_AW),
        .DMA_AW   (DMA_AW),
        .SEL_LO   (SEL_LO),
        .SEL_HI   (SEL_HI),
        .IDX_LO   (IDX_LO),
        .ENTRY_SH (ENTRY_SH)
    ) u_map (
        .bus_addr    (req_addr_i),
        .win_mask    (sel_mask),
        .win_xlat    (sel_xlat),
        .direct_addr (direct_addr),
        .entry_addr  (entry_addr)
    );

    assign pte_clr = rd_rsp_data_i & ~PTE_W'(1);
    assign sg_addr = DMA_AW'(pte_clr << PAGE_SH) | DMA_AW'(st_q.off);

    always_comb begin
        st_d         = st_q;
        st_d.rsp_vld = 1'b0;
        unique case (st_q.fsm)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (hit_sg) begin
                        st_d.fsm     = ST_FETCH;
                        st_d.rd_addr = entry_addr;
                        st_d.off     = req_addr_i[OFF_W-1:0];
                    end else begin
                        st_d.rsp_vld  = 1'b1;
                        st_d.rsp_addr = hit ? direct_addr : DMA_AW'(req_addr_i);
                    end
                end
            end
            ST_FETCH: begin
                if (rd_req_ready_i) begin
                    st_d.fsm = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rd_rsp_valid_i) begin
                    st_d.fsm      = ST_IDLE;
                    st_d.rsp_vld  = 1'b1;
                    st_d.rsp_addr = sg_addr;
                end
            end
            default: begin
                st_d.fsm = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fsm: ST_IDLE, rsp_vld: 1'b0, rsp_addr: '0, rd_addr: '0, off: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready_o    = (st_q.fsm == ST_IDLE);
    assign rd_req_valid_o = (st_q.fsm == ST_FETCH);
    assign rd_req_addr_o  = st_q.rd_addr;
    assign rsp_valid_o    = st_q.rsp_vld;
    assign rsp_addr_o     = st_q.rsp_addr;

endmodule

// File: rtl/pwt_chk.sv
module pwt_chk #(
    parameter int DMA_AW = 34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              rd_req_valid_o,
    input logic              rd_req_ready_i,
    input logic [DMA_AW-1:0] rd_req_addr_o,
    input logic              rd_rsp_valid_i,
    input logic              rsp_valid_o,
    input logic              hit_sg,
    input logic              wait_st
);

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid_o && !rd_req_valid_o && req_ready_o));

    // R6
    a_r6_direct_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && !hit_sg) |=> rsp_valid_o);

    // R7
    a_r7_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o && $stable(rd_req_addr_o)));

    // R7
    a_r7_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid_o |-> !req_ready_o);

    // R8
    a_r8_sg_next: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_st && rd_rsp_valid_i) |=> rsp_valid_o);

    // R9
    a_r9_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && hit_sg) |=> (!rsp_valid_o && rd_req_valid_o));

endmodule

bind pwt_xlate pwt_chk #(.DMA_AW(DMA_AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .rd_req_valid_o (rd_req_valid_o),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_req_addr_o  (rd_req_addr_o),
    .rd_rsp_valid_i (rd_rsp_valid_i),
    .rsp_valid_o    (rsp_valid_o),
    .hit_sg         (hit_sg),
    .wait_st        (st_q.fsm == pwt_pkg::ST_WAIT)
);

// File: tb/pwt_xlate_tb.sv
`timescale 1ns/1ps
module pwt_xlate_tb;

    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_addr = '0;
    logic [127:0]  win_base;
    logic [127:0]  win_mask;
    logic [135:0]  win_xlat;
    logic          rd_req_valid;
    logic          rd_req_ready = 1'b0;
    logic [33:0]   rd_req_addr;
    logic          rd_rsp_valid = 1'b0;
    logic [63:0]   rd_rsp_data = '0;
    logic          rsp_valid;
    logic [33:0]   rsp_addr;

    logic [63:0] bw [NW];
    logic [63:0] bm [NW];
    logic [63:0] bx [NW];

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit exp_win = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NW; i++) begin
            win_base[i*32 +: 32] = bw[i][31:0];
            win_mask[i*32 +: 32] = bm[i][31:0];
            win_xlat[i*34 +: 34] = bx[i][33:0];
        end
    end

    pwt_xlate u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid_i    (req_valid),
        .req_ready_o    (req_ready),
        .req_addr_i     (req_addr),
        .win_base_i     (win_base),
        .win_mask_i     (win_mask),
        .win_xlat_i     (win_xlat),
        .rd_req_valid_o (rd_req_valid),
        .rd_req_ready_i (rd_req_ready),
        .rd_req_addr_o  (rd_req_addr),
        .rd_rsp_valid_i (rd_rsp_valid),
        .rd_rsp_data_i  (rd_rsp_data),
        .rsp_valid_o    (rsp_valid),
        .rsp_addr_o     (rsp_addr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every-clock comparison of the response strobe against the model's window
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            check("R6/R9 response strobe", 64'(rsp_valid), 64'(exp_win));
        end
    end

    // behavioural reference: returns mode, entry address and direct/pass result
    function automatic void model(input logic [63:0] bus, output bit sg,
                                  output logic [63:0] ent, output logic [63:0] res);
        logic [63:0] wm, hi;
        sg  = 1'b0;
        ent = '0;
        res = bus & 64'h3_FFFF_FFFF;
        for (int i = 0; i < NW; i++) begin
            wm = ~bm[i] & 64'hFFF0_0000;
            if (((bus & wm) == (bw[i] & wm)) && bw[i][0]) begin
                hi = bm[i] & 64'hFFF0_0000;
                if (bw[i][1]) begin
                    sg  = 1'b1;
                    ent = ((bx[i] & ~((hi >> 10) | 64'h3FF)) |
                           ((bus & (hi | 64'hFE000)) >> 10)) & 64'h3_FFFF_FFFF;
                end else begin
                    res = ((bx[i] & ~(hi | 64'hFFFFF)) | (bus & (hi | 64'hFFFFF)))
                          & 64'h3_FFFF_FFFF;
                end
                return;
            end
        end
    endfunction

    function automatic logic [63:0] mem_entry(input logic [63:0] a);
        return {a[31:0], a[31:0]} ^ 64'hC000_0000_0F0F_1235;
    endfunction

    task automatic set_win(input int i, input logic [63:0] b, input logic [63:0] m,
                           input logic [63:0] x);
        bw[i] = b;
        bm[i] = m;
        bx[i] = x;
    endtask

    task automatic run_direct(input logic [31:0] bus, input string req);
        bit sg;
        logic [63:0] ent, res;
        model(64'(bus), sg, ent, res);
        @(negedge clk);
        check({req, " ready before accept"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = bus;
        @(negedge clk);
        req_valid = 1'b0;
        exp_win   = 1'b1;
        check({req, " R6 valid next cycle"}, 64'(rsp_valid), 64'd1);
        check({req, " result"}, 64'(rsp_addr), res);
        @(negedge clk);
        exp_win = 1'b0;
    endtask

    task automatic run_sg(input logic [31:0] bus, input int rdy_dly, input int rsp_dly,
                          input bit poke);
        bit sg;
        logic [63:0] ent, res, pte, exp;
        model(64'(bus), sg, ent, res);
        pte = mem_entry(ent);
        exp = (((pte & ~64'h1) << 12) | (64'(bus) & 64'h1FFF)) & 64'h3_FFFF_FFFF;
        check("R4 model picks scatter-gather", 64'(sg), 64'd1);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = bus;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 no response after SG accept", 64'(rsp_valid), 64'd0);
        check("R7 read request raised", 64'(rd_req_valid), 64'd1);
        check("R7 entry address", 64'(rd_req_addr), ent);
        check("R7 busy blocks requests", 64'(req_ready), 64'd0);
        if (poke) begin
            req_valid    = 1'b1;
            req_addr     = 32'h0000_0100;
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = 64'hFFFF_FFFF_FFFF_FFFF;
            @(negedge clk);
            req_valid    = 1'b0;
            rd_rsp_valid = 1'b0;
            check("R9 stray read data ignored", 64'(rsp_valid), 64'd0);
            check("R9 fetch still pending", 64'(rd_req_valid), 64'd1);
        end
        for (int k = 0; k < rdy_dly; k++) begin
            @(negedge clk);
            check("R7 request held", 64'(rd_req_valid), 64'd1);
            check("R7 address steady", 64'(rd_req_addr), ent);
        end
        rd_req_ready = 1'b1;
        @(negedge clk);
        rd_req_ready = 1'b0;
        check("R7 request drops after handshake", 64'(rd_req_valid), 64'd0);
        for (int k = 0; k < rsp_dly; k++) begin
            @(negedge clk);
            check("R7 still busy awaiting entry", 64'(req_ready), 64'd0);
        end
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = pte;
        @(negedge clk);
        rd_rsp_valid = 1'b0;
        exp_win      = 1'b1;
        check("R8 valid after read data", 64'(rsp_valid), 64'd1);
        check("R8 SG result", 64'(rsp_addr), exp);
        @(negedge clk);
        exp_win = 1'b0;
        check("R8 idle again", 64'(req_ready), 64'd1);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=<20000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) set_win(i, '0, '0, '0);
        repeat (3) @(negedge clk);
        check("R1 ready in reset", 64'(req_ready), 64'd1);
        check("R1 no response in reset", 64'(rsp_valid), 64'd0);
        check("R1 no read in reset", 64'(rd_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", 64'(req_ready), 64'd1);
        check("R1 idle after reset", 64'(rd_req_valid), 64'd0);

        // Phase A
        set_win(0, 64'h4000_0001, 64'h0030_0000, 64'h2_1230_0000);
        set_win(1, 64'h8000_0000, 64'h0000_0000, 64'h0_ABC0_0000);
        set_win(2, 64'h8000_0001, 64'h3FF0_0000, 64'h3_0000_0000);
        set_win(3, 64'hC000_0003, 64'h00F0_0000, 64'h1_2345_6000);
        run_direct(32'h4012_3456, "R2 R4 window0 direct");
        run_direct(32'h4033_FFFF, "R2 window0 masked bits");
        run_direct(32'h4040_0000, "R5 just past window0");
        run_direct(32'h8000_1234, "R3 disabled window1 skipped");
        run_direct(32'h0000_5000, "R5 pass through");
        run_direct(32'hFFFF_FFFF, "R5 pass through top");
        run_sg(32'hC0A1_2345, 3, 2, 1'b1);
        run_sg(32'hC0FF_FFFF, 0, 0, 1'b0);

        // Phase B: overlap and priority
        set_win(1, 64'h8000_0001, 64'h0000_0000, 64'h0_ABC0_0000);
        run_direct(32'h8000_1234, "R3 window1 before window2");
        run_direct(32'h8010_0000, "R3 window2 beyond window1");
        set_win(0, 64'h0000_0001, 64'hFFF0_0000, 64'h3_FFFF_F000);
        run_direct(32'hC0A1_2345, "R3 window0 covers all");
        run_direct(32'h1234_5678, "R4 full-mask window0");

        // Phase C: scatter-gather with wide mask
        set_win(0, 64'h0000_0003, 64'hFFF0_0000, 64'h3_8000_0000);
        run_sg(32'h89AB_CDEF, 1, 4, 1'b1);
        set_win(0, 64'h0000_0000, 64'hFFF0_0000, 64'h0);
        run_sg(32'hC055_1FFF, 2, 1, 1'b0);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule